// File: doc/BRIEF.md
# Maintenance configuration read responder

The block sits between an inbound and an outbound frame buffer and answers configuration read requests of the maintenance class. Each request is presented as a frame of 32-bit words. The block pulls the three header words of a request and checks that it is a single-doubleword maintenance read. It then writes a four-word response frame into the outbound buffer, after which it releases the inbound frame. Requests it does not serve are released without any response.

The readable space is two doublewords of constant identity data, set by parameters. Offset 0 holds a device identity word and a device revision word. Offset 1 holds an assembly identity word and an assembly information word. The word pointer picks which 32-bit half of the addressed doubleword carries data; the other half is returned as zero.

Inbound word layout: word 0 has source ID in [31:16] and destination ID in [15:0]. Word 1 has transaction code in [31:28], size code in [27:24], transaction ID in [23:16], hop count in [15:8] and frame class in [7:4]. Word 2 has the 21-bit doubleword offset in [31:11] and the word pointer in [10]. The response uses the same layout for its first two words, followed by the upper data word and then the lower data word.

Top module: `maint_cfg_responder`

## Requirements
- R1: After reset the block is idle: in_next, in_done, out_push and out_commit are all low while in_empty stays high.
- R2: A request with frame class 4'h8, transaction code 4'b0000 and size code 4'b1000 is answered with exactly four pushed words, and out_commit is high together with the fourth push.
- R3: Response word 0 is {request destination ID, request source ID}; response word 1 is {4'b0010, 4'b0000, request transaction ID, 8'hFF, 4'h8, 4'h0}.
- R4: At offset 0 the upper data word is {DEV_ID, DEV_VENDOR} and the lower data word is DEV_REV.
- R5: At offset 1 the upper data word is {ASSY_ID, ASSY_VENDOR} and the lower data word is {ASSY_REV, 16'h0000}.
- R6: Word pointer 0 returns the upper data word with the lower word zero; word pointer 1 returns the lower data word with the upper word zero.
- R7: Any offset other than 0 and 1 returns two zero data words in a normal response; all 21 offset bits are decoded.
- R8: A request with any other class, transaction code or size code gets no pushed word and no commit, and its frame is still released.
- R9: out_push is never high while out_full is high; a full outbound buffer stalls the response without losing words.
- R10: Each frame is released with exactly one in_done pulse, and that pulse comes only after the response (if any) has been committed.
- R11: Exactly three in_next pulses are issued per frame, all before any word of the response is pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_empty | input | 1 | No inbound frame is available |
| in_word | input | 32 | Current word of the inbound frame |
| in_next | output | 1 | Advance to the next inbound word |
| in_done | output | 1 | Release the current inbound frame |
| out_full | input | 1 | Outbound buffer cannot take a word |
| out_push | output | 1 | Write out_data into the outbound frame |
| out_commit | output | 1 | Close the outbound frame (with last push) |
| out_data | output | 32 | Outbound word |

## Verification
The assertions take for granted that when in_empty is low a whole request of at least three words is present, that in_word shows the current word and changes only after an in_next, and that in_empty rises no later than the cycle after in_done. The bench models the inbound buffer exactly that way: it loads a full frame before lowering in_empty, steps its word index only on in_next and raises in_empty on in_done. The out_full input is driven freely, including held high across a whole request, since the block must tolerate it at any time.

// File: rtl/maint_cfg_responder.sv
module maint_cfg_responder #(
  parameter logic [15:0] DEV_ID      = 16'h0A51,
  parameter logic [15:0] DEV_VENDOR  = 16'h7C02,
  parameter logic [31:0] DEV_REV     = 32'h0001_0203,
  parameter logic [15:0] ASSY_ID     = 16'h3344,
  parameter logic [15:0] ASSY_VENDOR = 16'h5566,
  parameter logic [15:0] ASSY_REV    = 16'h0789
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_empty,
  input  logic [31:0] in_word,
  output logic        in_next,
  output logic        in_done,
  input  logic        out_full,
  output logic        out_push,
  output logic        out_commit,
  output logic [31:0] out_data
);

  localparam int          OFF_W    = 21;
  localparam logic [3:0]  CLS_MNT  = 4'h8;
  localparam logic [3:0]  TT_RD    = 4'b0000;
  localparam logic [3:0]  TT_RESP  = 4'b0010;
  localparam logic [3:0]  SZ_ONE   = 4'b1000;
  localparam logic [7:0]  HOP_OUT  = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_CAP0, S_CAP1, S_CAP2,
    S_SEND0, S_SEND1, S_SEND2, S_SEND3, S_REL
  } st_t;

  st_t             st;
  logic [31:0]     ids;
  logic [3:0]      ttype, size, cls;
  logic [7:0]      tid;
  logic [OFF_W-1:0] off;
  logic            wptr;
  logic [31:0]     hi_w, lo_w, hi_raw, lo_raw;
  logic            req_ok;

  assign req_ok = (cls == CLS_MNT) && (ttype == TT_RD) && (size == SZ_ONE);

  assign in_next    = (st == S_CAP0) || (st == S_CAP1) || (st == S_CAP2);
  assign in_done    = (st == S_REL);
  assign out_push   = ((st == S_SEND0) || (st == S_SEND1) ||
                       (st == S_SEND2) || (st == S_SEND3)) && !out_full;
  assign out_commit = (st == S_SEND3) && !out_full;

  always_comb begin
    case (off)
      21'd0:   begin hi_raw = {DEV_ID, DEV_VENDOR};  lo_raw = DEV_REV;            end
      21'd1:   begin hi_raw = {ASSY_ID, ASSY_VENDOR}; lo_raw = {ASSY_REV, 16'h0}; end
      default: begin hi_raw = 32'h0;                  lo_raw = 32'h0;             end
    endcase
  end

  assign hi_w = wptr ? 32'h0 : hi_raw;
  assign lo_w = wptr ? lo_raw : 32'h0;

  always_comb begin
    case (st)
      S_SEND0: out_data = {ids[15:0], ids[31:16]};
      S_SEND1: out_data = {TT_RESP, 4'b0000, tid, HOP_OUT, CLS_MNT, 4'h0};
      S_SEND2: out_data = hi_w;
      S_SEND3: out_data = lo_w;
      default: out_data = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ids   <= '0;
      ttype <= '0;
      size  <= '0;
      cls   <= '0;
      tid   <= '0;
      off   <= '0;
      wptr  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!in_empty) st <= S_CAP0;
        S_CAP0: begin
          ids <= in_word;
          st  <= S_CAP1;
        end
        S_CAP1: begin
          ttype <= in_word[31:28];
          size  <= in_word[27:24];
          tid   <= in_word[23:16];
          cls   <= in_word[7:4];
          st    <= S_CAP2;
        end
        S_CAP2: begin
          off  <= in_word[31:11];
          wptr <= in_word[10];
          st   <= req_ok ? S_SEND0 : S_REL;
        end
        S_SEND0: if (!out_full) st <= S_SEND1;
        S_SEND1: if (!out_full) st <= S_SEND2;
        S_SEND2: if (!out_full) st <= S_SEND3;
        S_SEND3: if (!out_full) st <= S_REL;
        S_REL:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/maint_cfg_responder_chk.sv
module maint_cfg_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_next,
  input logic        in_done,
  input logic        out_full,
  input logic        out_push,
  input logic        out_commit,
  input logic [31:0] out_data
);

  logic [2:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (in_done) pc <= '0;
    else if (out_push) pc <= pc + 3'd1;
  end

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full);

  assert_commit_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_commit |-> (out_push && pc == 3'd3));

  assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> (pc < 3'd4));

  assert_release_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |-> (pc == 3'd0 || pc == 3'd4));

  assert_single_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> !in_done);

  assert_resp_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && pc == 3'd1) |-> (out_data[31:24] == 8'h20 && out_data[15:0] == 16'hFF80));

  assert_no_read_while_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_next |-> (!out_push && pc == 3'd0));

endmodule

bind maint_cfg_responder maint_cfg_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_next(in_next), .in_done(in_done),
  .out_full(out_full), .out_push(out_push), .out_commit(out_commit),
  .out_data(out_data)
);

// File: tb/maint_cfg_responder_tb.sv
module maint_cfg_responder_tb;

  localparam logic [15:0] P_DEV_ID   = 16'hD1D2;
  localparam logic [15:0] P_DEV_VEN  = 16'hB3B4;
  localparam logic [31:0] P_DEV_REV  = 32'hC5C6_C7C8;
  localparam logic [15:0] P_ASY_ID   = 16'h1A2B;
  localparam logic [15:0] P_ASY_VEN  = 16'h3C4D;
  localparam logic [15:0] P_ASY_REV  = 16'h5E6F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_empty = 1'b1;
  logic [31:0] in_word;
  logic in_next, in_done;
  logic out_full = 1'b0;
  logic out_push, out_commit;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] fr [0:7];
  logic [2:0]  idx;
  logic [31:0] cap [0:7];
  int pcnt, ncnt, commits, done_push, done_commits, done_next, full_push;

  always #2 clk = ~clk;

  assign in_word = fr[idx];

  maint_cfg_responder #(
    .DEV_ID(P_DEV_ID), .DEV_VENDOR(P_DEV_VEN), .DEV_REV(P_DEV_REV),
    .ASSY_ID(P_ASY_ID), .ASSY_VENDOR(P_ASY_VEN), .ASSY_REV(P_ASY_REV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_word(in_word),
    .in_next(in_next), .in_done(in_done), .out_full(out_full),
    .out_push(out_push), .out_commit(out_commit), .out_data(out_data)
  );

  always @(posedge clk) begin
    if (in_next) begin idx <= idx + 3'd1; ncnt <= ncnt + 1; end
    if (out_push) begin
      cap[pcnt[2:0]] <= out_data;
      pcnt <= pcnt + 1;
      if (out_full) full_push <= full_push + 1;
    end
    if (out_commit) commits <= commits + 1;
    if (in_done) begin
      in_empty     <= 1'b1;
      done_push    <= pcnt;
      done_commits <= commits;
      done_next    <= ncnt;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_req(input logic [15:0] src, input logic [15:0] dst,
                         input logic [3:0] tt, input logic [3:0] sz, input logic [3:0] cl,
                         input logic [7:0] tid, input logic [20:0] off, input logic wp,
                         input int full_cycles);
    @(negedge clk);
    fr[0] = {src, dst};
    fr[1] = {tt, sz, tid, 8'h33, cl, 4'h0};
    fr[2] = {off, wp, 10'h0};
    for (int k = 3; k < 8; k++) fr[k] = 32'h0;
    idx = 3'd0; pcnt = 0; ncnt = 0; commits = 0; full_push = 0;
    done_push = -1; done_commits = -1; done_next = -1;
    if (full_cycles > 0) out_full = 1'b1;
    in_empty = 1'b0;
    if (full_cycles > 0) begin
      repeat (full_cycles) @(negedge clk);
      chk(pcnt == 0 && in_empty == 1'b0, "R9 stall while full", pcnt, 0);
      out_full = 1'b0;
    end
    for (int t = 0; t < 200 && !in_empty; t++) @(negedge clk);
    chk(in_empty == 1'b1, "R10 frame released", {31'h0, in_empty}, 32'h1);
    chk(done_next == 3, "R11 three word reads", done_next, 3);
    chk(full_push == 0, "R9 no push while full", full_push, 0);
  endtask

  task automatic check_resp(input string tag, input logic [15:0] src, input logic [15:0] dst,
                            input logic [7:0] tid, input logic [31:0] hi, input logic [31:0] lo);
    chk(done_push == 4, "R2 four words pushed", done_push, 4);
    chk(done_commits == 1, "R10 committed before release", done_commits, 1);
    chk(cap[0] == {dst, src}, "R3 id swap", cap[0], {dst, src});
    chk(cap[1] == {4'b0010, 4'b0000, tid, 8'hFF, 4'h8, 4'h0}, "R3 code tid hop", cap[1],
        {4'b0010, 4'b0000, tid, 8'hFF, 4'h8, 4'h0});
    chk(cap[2] == hi, {tag, " upper word"}, cap[2], hi);
    chk(cap[3] == lo, {tag, " lower word"}, cap[3], lo);
  endtask

  task automatic check_drop(input string tag);
    chk(done_push == 0, {tag, " no push"}, done_push, 0);
    chk(commits == 0, {tag, " no commit"}, commits, 0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) fr[k] = 32'h0;
    idx = 3'd0;
    repeat (3) @(negedge clk);
    chk(!in_next && !in_done && !out_push && !out_commit, "R1 idle after reset",
        {28'h0, in_next, in_done, out_push, out_commit}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!in_next && !in_done && !out_push && !out_commit, "R1 idle with empty buffer",
        {28'h0, in_next, in_done, out_push, out_commit}, 32'h0);
  endtask

  task automatic t_dev_upper();
    run_req(16'hDEAD, 16'hBEEF, 4'b0000, 4'b1000, 4'h8, 8'hAA, 21'd0, 1'b0, 0);
    check_resp("R4 R6 dev wptr0", 16'hDEAD, 16'hBEEF, 8'hAA, {P_DEV_ID, P_DEV_VEN}, 32'h0);
  endtask

  task automatic t_dev_lower();
    run_req(16'h1234, 16'h5678, 4'b0000, 4'b1000, 4'h8, 8'h07, 21'd0, 1'b1, 0);
    check_resp("R4 R6 dev wptr1", 16'h1234, 16'h5678, 8'h07, 32'h0, P_DEV_REV);
  endtask

  task automatic t_assy_upper();
    run_req(16'h0001, 16'h0002, 4'b0000, 4'b1000, 4'h8, 8'h5C, 21'd1, 1'b0, 0);
    check_resp("R5 R6 assy wptr0", 16'h0001, 16'h0002, 8'h5C, {P_ASY_ID, P_ASY_VEN}, 32'h0);
  endtask

  task automatic t_assy_lower();
    run_req(16'hA0A0, 16'h0B0B, 4'b0000, 4'b1000, 4'h8, 8'hF1, 21'd1, 1'b1, 0);
    check_resp("R5 R6 assy wptr1", 16'hA0A0, 16'h0B0B, 8'hF1, 32'h0, {P_ASY_REV, 16'h0});
  endtask

  task automatic t_unimpl();
    run_req(16'h4444, 16'h5555, 4'b0000, 4'b1000, 4'h8, 8'h10, 21'd5, 1'b0, 0);
    check_resp("R7 offset 5", 16'h4444, 16'h5555, 8'h10, 32'h0, 32'h0);
    run_req(16'h4444, 16'h5555, 4'b0000, 4'b1000, 4'h8, 8'h11, 21'h100000, 1'b0, 0);
    check_resp("R7 offset high bit alias", 16'h4444, 16'h5555, 8'h11, 32'h0, 32'h0);
    run_req(16'h4444, 16'h5555, 4'b0000, 4'b1000, 4'h8, 8'h12, 21'h100001, 1'b1, 0);
    check_resp("R7 offset high bit alias lower", 16'h4444, 16'h5555, 8'h12, 32'h0, 32'h0);
  endtask

  task automatic t_drop();
    run_req(16'h1111, 16'h2222, 4'b0001, 4'b1000, 4'h8, 8'h20, 21'd0, 1'b0, 0);
    check_drop("R8 write transaction");
    run_req(16'h1111, 16'h2222, 4'b0000, 4'b0100, 4'h8, 8'h21, 21'd0, 1'b0, 0);
    check_drop("R8 other size");
    run_req(16'h1111, 16'h2222, 4'b0000, 4'b1000, 4'h2, 8'h22, 21'd0, 1'b0, 0);
    check_drop("R8 other class");
  endtask

  task automatic t_full();
    run_req(16'hCAFE, 16'hF00D, 4'b0000, 4'b1000, 4'h8, 8'h99, 21'd0, 1'b0, 25);
    check_resp("R9 after stall", 16'hCAFE, 16'hF00D, 8'h99, {P_DEV_ID, P_DEV_VEN}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_dev_upper();
    t_dev_lower();
    t_assy_upper();
    t_assy_lower();
    t_unimpl();
    t_drop();
    t_full();
    t_dev_upper();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

endmodule